// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts hardware events for profiling. It holds one cycle counter and two event counters, all 32 bits wide. Each event counter has an 8-bit selector that picks one line from a vector of single-cycle event pulses. A four-entry register port gives software access to a packed control/status word and to the three counter values. A level interrupt signals counter overflow.

A profiler loads a counter with the two's-complement negative of its sampling period and sets the matching interrupt enable. It then sets the global run bit. When the counter wraps, a sticky flag rises and raises the interrupt. The handler reloads the counter and clears the flags by writing back the control word it just read. The cycle counter can be slowed to one step every 64 clocks, so long intervals fit in 32 bits.

Top module: `perf_mon_top`

## Requirements
- R1: While control bit 0 (run) is 0, none of the three counters changes except by a software write or a reset bit.
- R2: Writing control with bit 1 set zeroes both event counters. Writing control with bit 2 set zeroes the cycle counter and its divide phase. Both bits always read back as 0.
- R3: With control bit 3 set, the cycle counter steps once per 64 run cycles, counted from its last reset. With bit 3 clear, it steps on every run cycle.
- R4: Register addresses are 0 for control, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. All three counters can be written and read back. Preloading the value -N makes a counter wrap after exactly N counted steps.
- R5: Control bits [19:12] select the event for counter 0, and bits [27:20] select the event for counter 1. A value from 0 to 31 picks that bit of `events`. The counter adds one on each run cycle in which that bit is high.
- R6: A selector of 0xFF, or any value from 32 to 0xFE, never advances its counter.
- R7: When a counter wraps from 0xFFFFFFFF to 0, its sticky flag is set and the count continues from 0. The flags are control bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it. Writing back a control word that was just read therefore clears every flag that was set.
- R9: `irq` is registered. It is high one cycle after any flag is set together with its enable, and low one cycle after no such pair remains. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R10: A software write to a counter in the same cycle as an increment stores the written value. An overflow in the same cycle as a clear of that flag leaves the flag set.
- R11: After reset, every register reads 0 and `irq` is low. `reg_rdata` shows the register addressed one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| events | input | EVT_W (32) | Event pulse lines, one bit per event source |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the register addressed in the previous cycle |
| irq | output | 1 | Registered overflow interrupt level |

## Verification
The bench builds the block with its defaults: 32-bit counters, a 32-line event vector and a divide ratio of 64. With these values every valid selector of both event counters is swept against a fixed event pattern, alongside several invalid selectors. Preloading counters close to 0xFFFFFFFF brings the overflow, interrupt and flag-clear collisions within a few cycles. A full 64-cycle divide window fits many times into the run.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W      = 32;
  localparam int SEL_W       = 8;
  localparam int NUM_EV      = 2;
  localparam int NUM_CTR     = NUM_EV + 1;

  // control word bit positions (decoded by software)
  localparam int B_RUN       = 0;
  localparam int B_EV_RST    = 1;
  localparam int B_CY_RST    = 2;
  localparam int B_DIV       = 3;
  localparam int B_IE        = 4;
  localparam int B_FLAG      = 8;
  localparam int B_SEL       = 12;

  // counter slot order inside the enable and flag fields
  localparam int IDX_CYC     = NUM_EV;

  localparam logic [SEL_W-1:0] SEL_OFF = '1;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CYC  = 2'd1,
    RA_EV0  = 2'd2,
    RA_EV1  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // a load or clear in the same cycle suppresses the step and its wrap
  assign wrap = inc & ~ld & ~clr & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic div_on,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = div_on ? (phase == LAST) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= '0;
    else if (run)    phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/pmu_event_sel.sv
module pmu_event_sel #(
  parameter int EVT_W = 32,
  parameter int SEL_W = 8
) (
  input  logic [EVT_W-1:0] events,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             hit
);
  localparam int IW = (EVT_W > 1) ? $clog2(EVT_W) : 1;
  localparam logic [SEL_W-1:0] OFF = '1;

  logic in_range;
  assign in_range = (int'(sel) < EVT_W) && (sel != OFF);
  assign hit      = run & in_range & events[sel[IW-1:0]];
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int NEV = NUM_EV
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NEV:0]              wrap,
  output logic                      run,
  output logic                      div_on,
  output logic [NEV:0]              ie,
  output logic [NEV:0]              flags,
  output logic [NEV-1:0][SEL_W-1:0] sel,
  output logic                      ev_rst,
  output logic                      cy_rst
);
  localparam int NC = NEV + 1;

  assign ev_rst = wr & wdata[B_EV_RST];
  assign cy_rst = wr & wdata[B_CY_RST];

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      div_on <= 1'b0;
      ie     <= '0;
    end else if (wr) begin
      run    <= wdata[B_RUN];
      div_on <= wdata[B_DIV];
      ie     <= wdata[B_IE +: NC];
    end
  end

  for (genvar g = 0; g < NEV; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)     sel[g] <= '0;
      else if (wr) sel[g] <= wdata[B_SEL + g*SEL_W +: SEL_W];
    end
  end

  // new overflow outranks a write-one clear in the same cycle
  for (genvar c = 0; c < NC; c++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flags[c] <= 1'b0;
      else if (wrap[c]) flags[c] <= 1'b1;
      else if (wr && wdata[B_FLAG + c]) flags[c] <= 1'b0;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:B_SEL + NEV*SEL_W], wdata[B_FLAG-1:B_IE+NC],
                          wdata[B_SEL-1:B_FLAG+NC]};
endmodule

// File: rtl/perf_mon_top.sv
module perf_mon_top
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EVT_W = 32,
  parameter int DIV   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  events,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int NC = NUM_CTR;

  logic                         run, div_on, ev_rst, cy_rst, tick;
  logic [NC-1:0]                ie, flags, wrap;
  logic [NUM_EV-1:0][SEL_W-1:0] ev_sel;
  logic [NUM_EV-1:0][CNT_W-1:0] ev_cnt;
  logic [CNT_W-1:0]             cyc_cnt;
  logic [DATA_W-1:0]            ctrl_word;

  pmu_ctrl #(.NEV(NUM_EV)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr(reg_wr && reg_addr == RA_CTRL), .wdata(reg_wdata), .wrap(wrap),
    .run(run), .div_on(div_on), .ie(ie), .flags(flags), .sel(ev_sel),
    .ev_rst(ev_rst), .cy_rst(cy_rst)
  );

  pmu_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clr(cy_rst), .run(run), .div_on(div_on), .tick(tick)
  );

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst(rst), .inc(run & tick), .clr(cy_rst),
    .ld(reg_wr && reg_addr == RA_CYC), .ld_val(reg_wdata[CNT_W-1:0]),
    .cnt(cyc_cnt), .wrap(wrap[IDX_CYC])
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    logic hit;
    pmu_event_sel #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_sel (
      .events(events), .sel(ev_sel[g]), .run(run), .hit(hit)
    );
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(hit), .clr(ev_rst),
      .ld(reg_wr && reg_addr == 2'(int'(RA_EV0) + g)),
      .ld_val(reg_wdata[CNT_W-1:0]),
      .cnt(ev_cnt[g]), .wrap(wrap[g])
    );
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_RUN]        = run;
    ctrl_word[B_DIV]        = div_on;
    ctrl_word[B_IE +: NC]   = ie;
    ctrl_word[B_FLAG +: NC] = flags;
    for (int g = 0; g < NUM_EV; g++)
      ctrl_word[B_SEL + g*SEL_W +: SEL_W] = ev_sel[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(flags & ie);
      case (reg_addr)
        RA_CTRL: reg_rdata <= ctrl_word;
        RA_CYC:  reg_rdata <= DATA_W'(cyc_cnt);
        RA_EV0:  reg_rdata <= DATA_W'(ev_cnt[0]);
        default: reg_rdata <= DATA_W'(ev_cnt[1]);
      endcase
    end
  end
endmodule

// File: rtl/pmu_mon_chk.sv
module pmu_mon_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_rdata,
  input logic             irq,
  input logic             run,
  input logic [2:0]       ie,
  input logic [2:0]       flags,
  input logic [7:0]       sel0,
  input logic [CNT_W-1:0] cyc,
  input logic [CNT_W-1:0] ev0,
  input logic [CNT_W-1:0] ev1
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !reg_wr) |=> ($stable(cyc) && $stable(ev0) && $stable(ev1)));

  // R2
  rst_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd0) |=> (reg_rdata[2:1] == 2'b00));

  // R6
  sel_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sel0 == 8'hFF && !reg_wr) |=> $stable(ev0));

  // R7
  flag_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> (ev0 == '0));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ie)) |=> irq);

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ie)) |=> !irq);
endmodule

bind perf_mon_top pmu_mon_chk #(.CNT_W(CNT_W)) u_mon_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq), .run(run), .ie(ie), .flags(flags),
  .sel0(ev_sel[0]), .cyc(cyc_cnt), .ev0(ev_cnt[0]), .ev1(ev_cnt[1])
);

// File: tb/tb_perf_mon_top.sv
module tb_perf_mon_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PAT = 32'h6B1D_92E5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] events = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  logic       c_div;
  logic [2:0] c_ie;
  logic [7:0] c_s0, c_s1;

  perf_mon_top dut (.clk(clk), .rst(rst), .events(events), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(bit en, bit evr, bit cyr, bit dv, logic [2:0] ie_v,
                                     logic [2:0] fl, logic [7:0] s0, logic [7:0] s1);
    return {4'b0, s1, s0, 1'b0, fl, 1'b0, ie_v, dv, cyr, evr, en};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic cfg(bit evr, bit cyr, bit dv, logic [2:0] ie_v, logic [2:0] fl,
                     logic [7:0] s0, logic [7:0] s1);
    c_div = dv; c_ie = ie_v; c_s0 = s0; c_s1 = s1;
    wr(2'd0, mk(0, evr, cyr, dv, ie_v, fl, s0, s1));
  endtask

  // exactly n counting edges
  task automatic run(int n);
    wr(2'd0, mk(1, 0, 0, c_div, c_ie, 3'b000, c_s0, c_s1));
    repeat (n - 1) @(negedge clk);
    wr(2'd0, mk(0, 0, 0, c_div, c_ie, 3'b000, c_s0, c_s1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R11: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, cw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R11 reset reg", v, 32'h0);
    end
    chk("R11 reset irq", {31'b0, irq}, 32'h0);

    // R1 run bit off: pulses ignored
    events = '1;
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R1 cyc idle", v, 0);
    rd(2'd2, v); chk("R1 ev0 idle", v, 0);
    rd(2'd3, v); chk("R1 ev1 idle", v, 0);

    // R5 sweep of all valid selectors on both counters
    events = PAT;
    for (int k = 0; k < 32; k++) begin
      int s1 = (k * 7 + 3) % 32;
      int n  = k + 2;
      cfg(1, 1, 0, 3'b000, 3'b000, 8'(k), 8'(s1));
      run(n);
      rd(2'd2, v); chk("R5 ev0 sweep", v, PAT[k] ? n : 0);
      rd(2'd3, v); chk("R5 ev1 sweep", v, PAT[s1] ? n : 0);
      rd(2'd1, v); chk("R1 cyc run", v, n);
    end

    // R6 out-of-range and off selectors
    events = '1;
    foreach (v[i]) begin end
    begin
      logic [7:0] bad [3] = '{8'h20, 8'h7F, 8'hFE};
      for (int i = 0; i < 3; i++) begin
        cfg(1, 1, 0, 3'b000, 3'b000, bad[i], 8'hFF);
        run(10);
        rd(2'd2, v); chk("R6 ev0 bad sel", v, 0);
        rd(2'd3, v); chk("R6 ev1 off sel", v, 0);
      end
    end

    // R4 counter read/write
    wr(2'd1, 32'hDEAD_BEEF); wr(2'd2, 32'h1234_5678); wr(2'd3, 32'h8000_0001);
    rd(2'd1, v); chk("R4 cyc rw", v, 32'hDEAD_BEEF);
    rd(2'd2, v); chk("R4 ev0 rw", v, 32'h1234_5678);
    rd(2'd3, v); chk("R4 ev1 rw", v, 32'h8000_0001);

    // R2 reset bits
    cfg(1, 0, 0, 3'b000, 3'b000, 8'h00, 8'h00);
    rd(2'd2, v); chk("R2 ev0 cleared", v, 0);
    rd(2'd3, v); chk("R2 ev1 cleared", v, 0);
    rd(2'd1, v); chk("R2 cyc kept", v, 32'hDEAD_BEEF);
    cfg(0, 1, 0, 3'b000, 3'b000, 8'h00, 8'h00);
    rd(2'd1, v); chk("R2 cyc cleared", v, 0);
    rd(2'd0, v); chk("R2 bits read 0", v, mk(0, 0, 0, 0, 0, 0, 0, 0));

    // R4 R7 R9 overflow of event counter 0 with enable
    cfg(0, 0, 0, 3'b001, 3'b000, 8'd3, 8'hFF);
    wr(2'd2, -32'd5);
    run(5);
    rd(2'd2, v); chk("R4 ev0 wraps after N", v, 0);
    rd(2'd0, cw); chk("R7 flag ev0", cw, mk(0, 0, 0, 0, 3'b001, 3'b001, 8'd3, 8'hFF));
    chk("R9 irq high", {31'b0, irq}, 1);
    run(7);
    rd(2'd2, v); chk("R7 keeps counting", v, 7);
    // R8 write back what was read
    wr(2'd0, cw);
    rd(2'd0, v); chk("R8 flags cleared", v, mk(0, 0, 0, 0, 3'b001, 3'b000, 8'd3, 8'hFF));
    chk("R9 irq low", {31'b0, irq}, 0);

    // R9 flag without enable leaves irq low
    cfg(0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'd4);
    wr(2'd3, -32'd2);
    run(2);
    rd(2'd0, v); chk("R7 flag ev1", v, mk(0, 0, 0, 0, 3'b000, 3'b010, 8'hFF, 8'd4));
    chk("R9 irq masked", {31'b0, irq}, 0);
    cfg(0, 0, 0, 3'b000, 3'b010, 8'hFF, 8'd4);
    rd(2'd0, v); chk("R8 flag ev1 cleared", v, mk(0, 0, 0, 0, 0, 0, 8'hFF, 8'd4));

    // R3 divide by 64 on the cycle counter
    cfg(0, 1, 1, 3'b100, 3'b000, 8'hFF, 8'hFF);
    wr(2'd1, -32'd3);
    run(192);
    rd(2'd1, v); chk("R3 cyc divided wrap", v, 0);
    rd(2'd0, cw); chk("R7 flag cyc", cw, mk(0, 0, 0, 1, 3'b100, 3'b100, 8'hFF, 8'hFF));
    chk("R9 irq cyc", {31'b0, irq}, 1);
    cfg(0, 0, 1, 3'b100, 3'b100, 8'hFF, 8'hFF);
    run(100);
    rd(2'd1, v); chk("R3 cyc one step", v, 1);
    chk("R9 irq cleared", {31'b0, irq}, 0);

    // R10 write beats increment
    cfg(0, 0, 0, 3'b001, 3'b000, 8'd3, 8'hFF);
    wr(2'd0, mk(1, 0, 0, 0, 3'b001, 0, 8'd3, 8'hFF));
    wr(2'd2, 32'h0000_0100);
    wr(2'd0, mk(0, 0, 0, 0, 3'b001, 0, 8'd3, 8'hFF));
    rd(2'd2, v); chk("R10 write wins", v, 32'h0000_0101);

    // R10 overflow beats clear
    wr(2'd2, 32'hFFFF_FFFF);
    run(1);
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd0, mk(1, 0, 0, 0, 3'b001, 0, 8'd3, 8'hFF));
    @(negedge clk);
    wr(2'd0, mk(1, 0, 0, 0, 3'b001, 3'b001, 8'd3, 8'hFF));
    wr(2'd0, mk(0, 0, 0, 0, 3'b001, 0, 8'd3, 8'hFF));
    rd(2'd2, v); chk("R10 count after wrap", v, 1);
    rd(2'd0, v); chk("R10 overflow wins", v, mk(0, 0, 0, 0, 3'b001, 3'b001, 8'd3, 8'hFF));
    wr(2'd0, mk(0, 0, 0, 0, 3'b001, 3'b001, 8'd3, 8'hFF));
    rd(2'd0, v); chk("R8 plain clear", v, mk(0, 0, 0, 0, 3'b001, 0, 8'd3, 8'hFF));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule